// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Angle Register

This block takes a 16-bit binary angle word from one parallel data bus and keeps it for two independent converter channels, A and B. Each channel owns a two-byte input stage and a 16-bit holding stage. The input stage is written a byte at a time. The upper byte and the lower byte each load under their own enable. A separate load control then copies the whole input stage into the holding stage. The holding stage drives the channel's angle output and a two-bit quadrant output. Software can therefore assemble a new angle over several bus cycles, and the converter sees the change in one step.

Each stage is a synchronous register. It follows its input on every clock edge while its enable is high, and it keeps its value while the enable is low. Bus bit 15 is the most significant angle bit, with a weight of 180 degrees. Bus bit 0 is the least significant bit. The angle is the sum of the weights of the set bits. Any enable value other than a firm logic 0 counts as high, so an undriven enable leaves its stage transparent.

Each channel decodes its controls into one of four modes on every clock:
- Idle: no control is high, and nothing changes.
- Stage: only a byte enable is high, and the input stage loads.
- Transfer: only the load control is high, and the holding stage takes the input stage.
- Flow: a byte enable and the load control are high together, and the holding stage takes the stage contents including this cycle's new bytes.

A channel moves between these modes freely on every cycle. The next mode depends only on the controls sampled at that edge.

Top module: `dual_angle_latch`

## Requirements
- R1: While `rst_n` is low, the input stages and the holding stages of both channels clear to zero (0 degrees). Both angle outputs and both quadrant outputs read zero.
- R2: At a clock edge where a channel's upper-byte enable is high, that channel's stage bits 15:8 take `data_in[15:8]`. Bit 15 is the MSB and has a weight of 180 degrees.
- R3: At a clock edge where a channel's lower-byte enable is high, that channel's stage bits 7:0 take `data_in[7:0]`. The upper byte is unaffected unless its own enable is also high.
- R4: A stage byte whose enable is low keeps its value, whatever the bus carries. This is observed at the angle output after a later load.
- R5: At an edge where a channel's load control is low, its angle output does not change, even if the byte enables or the bus change.
- R6: At an edge where a channel's load control is high, its angle output takes the full 16-bit stage contents one cycle after that edge.
- R7: When a byte enable and the load control are both high at the same edge, the angle output takes the newly written byte from the bus at that edge (flow-through).
- R8: The two channels share `data_in` but nothing else. Controls of one channel never change the other channel's stage or angle.
- R9: Each quadrant output equals bits 15:14 of that channel's held angle: 00 = 0 to 90 degrees, 01 = 90 to 180, 10 = 180 to 270, 11 = 270 to 360.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 16 | Shared angle bus, bit 15 = MSB |
| a_hi_en | input | 1 | Channel A upper-byte enable |
| a_lo_en | input | 1 | Channel A lower-byte enable |
| a_load | input | 1 | Channel A transfer to holding stage |
| b_hi_en | input | 1 | Channel B upper-byte enable |
| b_lo_en | input | 1 | Channel B lower-byte enable |
| b_load | input | 1 | Channel B transfer to holding stage |
| a_angle | output | 16 | Channel A held angle |
| a_quad | output | 2 | Channel A quadrant |
| b_angle | output | 16 | Channel B held angle |
| b_quad | output | 2 | Channel B quadrant |

## Verification
A byte written at an edge can be seen at the angle output only through a load. That load may come at the same edge (flow-through) or at a later edge. In either case the angle and quadrant outputs change right after the edge where the load is sampled high, which is a latency of exactly one clock. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares all four outputs of both channels at the next falling edge, so each result is checked in the cycle it becomes due. Hold behaviour is tested by writing the upper and lower bytes on different cycles and confirming that nothing moves until the load.

// File: rtl/angle_pkg.sv
package angle_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_STAGE = 2'd1,
        CH_XFER  = 2'd2,
        CH_FLOW  = 2'd3
    } ch_mode_e;

    // An enable that is not firmly low behaves as if pulled high.
    function automatic logic pulled_high(input logic en);
        return (en !== 1'b0);
    endfunction

endpackage

// File: rtl/angle_channel.sv
module angle_channel
    import angle_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int QUAD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] bus,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic              load,
    output logic [WORD_W-1:0] held,
    output logic [QUAD_W-1:0] quad
);
    localparam int HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic [WORD_W-1:0] held_q, held_d;
    logic              hi_on, lo_on, ld_on;
    ch_mode_e          mode;

    assign hi_on = pulled_high(hi_en);
    assign lo_on = pulled_high(lo_en);
    assign ld_on = pulled_high(load);

    // Mode decode
    always_comb begin
        unique case ({ld_on, (hi_on | lo_on)})
            2'b00:   mode = CH_IDLE;
            2'b01:   mode = CH_STAGE;
            2'b10:   mode = CH_XFER;
            default: mode = CH_FLOW;
        endcase
    end

    // Next-state values per mode
    always_comb begin
        hi_d   = hi_on ? bus[WORD_W-1:HALF_W] : hi_q;
        lo_d   = lo_on ? bus[HALF_W-1:0]      : lo_q;
        held_d = held_q;
        unique case (mode)
            CH_IDLE:  held_d = held_q;
            CH_STAGE: held_d = held_q;
            CH_XFER:  held_d = {hi_q, lo_q};
            CH_FLOW:  held_d = {hi_d, lo_d};
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            held_q <= '0;
        end else begin
            hi_q   <= hi_d;
            lo_q   <= lo_d;
            held_q <= held_d;
        end
    end

    assign held = held_q;
    assign quad = held_q[WORD_W-1 -: QUAD_W];

endmodule

// File: rtl/dual_angle_latch.sv
module dual_angle_latch #(
    parameter int WORD_W = 16,
    parameter int QUAD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_in,
    input  logic              a_hi_en,
    input  logic              a_lo_en,
    input  logic              a_load,
    input  logic              b_hi_en,
    input  logic              b_lo_en,
    input  logic              b_load,
    output logic [WORD_W-1:0] a_angle,
    output logic [QUAD_W-1:0] a_quad,
    output logic [WORD_W-1:0] b_angle,
    output logic [QUAD_W-1:0] b_quad
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0] hi_v, lo_v, ld_v;
    logic [WORD_W-1:0] held_v [NUM_CH];
    logic [QUAD_W-1:0] quad_v [NUM_CH];

    assign hi_v = {b_hi_en, a_hi_en};
    assign lo_v = {b_lo_en, a_lo_en};
    assign ld_v = {b_load,  a_load};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        angle_channel #(
            .WORD_W(WORD_W),
            .QUAD_W(QUAD_W)
        ) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .bus  (data_in),
            .hi_en(hi_v[ch]),
            .lo_en(lo_v[ch]),
            .load (ld_v[ch]),
            .held (held_v[ch]),
            .quad (quad_v[ch])
        );
    end

    assign a_angle = held_v[0];
    assign a_quad  = quad_v[0];
    assign b_angle = held_v[1];
    assign b_quad  = quad_v[1];

endmodule

// File: rtl/angle_latch_props.sv
module angle_latch_props (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] data_in,
    input logic        a_hi_en,
    input logic        a_lo_en,
    input logic        a_load,
    input logic        b_hi_en,
    input logic        b_lo_en,
    input logic        b_load,
    input logic [15:0] a_angle,
    input logic [1:0]  a_quad,
    input logic [15:0] b_angle,
    input logic [1:0]  b_quad
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (a_angle == 16'h0 && b_angle == 16'h0));

    assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !a_load |=> $stable(a_angle));

    assert_hold_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !b_load |=> $stable(b_angle));

    assert_flow_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_load && a_hi_en && a_lo_en) |=> a_angle == $past(data_in));

    assert_flow_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_load && b_hi_en && b_lo_en) |=> b_angle == $past(data_in));

    assert_quad_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_load && a_hi_en) |=> a_quad == $past(data_in[15:14]));

    assert_quad_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_load && b_hi_en) |=> b_quad == $past(data_in[15:14]));

endmodule

bind dual_angle_latch angle_latch_props u_props (.*);

// File: tb/sim_dual_angle_latch.sv
`timescale 1ns/1ps
module sim_dual_angle_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic        a_hi_en = 0, a_lo_en = 0, a_load = 0;
    logic        b_hi_en = 0, b_lo_en = 0, b_load = 0;
    logic [15:0] a_angle, b_angle;
    logic [1:0]  a_quad, b_quad;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // Behavioural reference model
    int m_hi [2];
    int m_lo [2];
    int m_held [2];

    always #4 clk = ~clk;

    dual_angle_latch u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .a_hi_en(a_hi_en), .a_lo_en(a_lo_en), .a_load(a_load),
        .b_hi_en(b_hi_en), .b_lo_en(b_lo_en), .b_load(b_load),
        .a_angle(a_angle), .a_quad(a_quad),
        .b_angle(b_angle), .b_quad(b_quad)
    );

    always @(posedge clk) begin
        bit hi [2];
        bit lo [2];
        bit ld [2];
        hi[0] = a_hi_en; lo[0] = a_lo_en; ld[0] = a_load;
        hi[1] = b_hi_en; lo[1] = b_lo_en; ld[1] = b_load;
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_hi[c] = 0; m_lo[c] = 0; m_held[c] = 0;
            end else begin
                if (hi[c]) m_hi[c] = data_in / 256;
                if (lo[c]) m_lo[c] = data_in % 256;
                if (ld[c]) m_held[c] = m_hi[c] * 256 + m_lo[c];
            end
        end
    end

    task automatic check_one(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check_one("a_angle", int'(a_angle), m_held[0]);
        check_one("a_quad",  int'(a_quad),  m_held[0] / 16384);
        check_one("b_angle", int'(b_angle), m_held[1]);
        check_one("b_quad",  int'(b_quad),  m_held[1] / 16384);
    endtask

    // Called at a falling edge: drive, wait one cycle, compare.
    task automatic step(input logic [15:0] d,
                        input logic ah, input logic al, input logic ald,
                        input logic bh, input logic bl, input logic bld,
                        input string ph);
        phase = ph;
        data_in = d;
        a_hi_en = ah; a_lo_en = al; a_load = ald;
        b_hi_en = bh; b_lo_en = bl; b_load = bld;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with controls active during reset
        data_in = 16'hFFFF;
        a_hi_en = 1; a_lo_en = 1; a_load = 1;
        b_hi_en = 1; b_lo_en = 1; b_load = 1;
        repeat (3) @(negedge clk);
        phase = "R1";
        check_one("a_angle", int'(a_angle), 0);
        check_one("b_angle", int'(b_angle), 0);
        check_one("a_quad",  int'(a_quad),  0);
        check_one("b_quad",  int'(b_quad),  0);
        step(16'h0000, 0, 0, 0, 0, 0, 0, "R1");
        rst_n = 1;
        step(16'h1234, 0, 0, 0, 0, 0, 0, "R1");

        // R2: upper byte only, no load -> held stays 0 (R5)
        step(16'hA5FF, 1, 0, 0, 0, 0, 0, "R2");
        step(16'h0000, 0, 0, 0, 0, 0, 0, "R5");
        // R3: lower byte at a different time
        step(16'hFF3C, 0, 1, 0, 0, 0, 0, "R3");
        step(16'h7777, 0, 0, 0, 0, 0, 0, "R5");
        // R6: transfer, expect A5_3C
        step(16'h0000, 0, 0, 1, 0, 0, 0, "R6");
        check_one("a_angle_R6", int'(a_angle), 16'hA53C);
        // R4: bus changes with enables low, then load -> unchanged
        step(16'h1111, 0, 0, 0, 0, 0, 0, "R4");
        step(16'h2222, 0, 0, 1, 0, 0, 0, "R4");
        check_one("a_angle_R4", int'(a_angle), 16'hA53C);
        // R5: enables toggle without load
        step(16'h4C4C, 1, 1, 0, 0, 0, 0, "R5");
        check_one("a_angle_R5", int'(a_angle), 16'hA53C);
        // R7: flow-through on upper byte only
        step(16'h80AA, 1, 0, 1, 0, 0, 0, "R7");
        check_one("a_angle_R7", int'(a_angle), 16'h804C);
        step(16'hC3D2, 1, 1, 1, 0, 0, 0, "R7");
        check_one("a_angle_R7b", int'(a_angle), 16'hC3D2);
        // R8: channel B alone, A must not move
        step(16'h5A01, 0, 0, 0, 1, 0, 0, "R8");
        step(16'h0099, 0, 0, 0, 0, 1, 1, "R8");
        check_one("b_angle_R8", int'(b_angle), 16'h5A99);
        check_one("a_angle_R8", int'(a_angle), 16'hC3D2);
        // R8: shared bus loading both channels at once
        step(16'h6E6E, 1, 1, 1, 1, 1, 1, "R8");
        // R9: quadrant sweep on A by flow-through
        for (int q = 0; q < 4; q++) begin
            step(16'(q * 16384 + 16'h0123), 1, 1, 1, 0, 0, 0, "R9");
            check_one("a_quad_R9", int'(a_quad), q);
        end
        // Mixed pattern across both channels
        for (int i = 0; i < 40; i++) begin
            step(16'(i * 16'h3B17 + 16'h0F0F),
                 i[0], i[1], i[2], i[1], i[3], i[0] ^ i[2], "R8");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule